// File: doc/BRIEF.md
# LPI Pending Table Priority Tracker

This block holds the pending state of message-based interrupts (LPIs) for one CPU interface. The state lives in a pending bit table in external memory. The block also keeps track of the best pending LPI. It reaches memory through one byte-wide port. A read returns its data one cycle after the strobe. The same port reads a second table, which holds one configuration byte per LPI: an enable bit and a priority field.

A set or clear request carries an interrupt ID and a level. The block turns it into a read-modify-write of one pending byte. When a bit is newly set, that single ID is compared against the current best. When the bit of the current best is cleared, the block runs a full rescan of the table. A control write enables or disables LPIs, and enabling also starts a rescan. The ID width field, the two table bases and a security-disable flag are held steady by the surrounding logic while the block runs.

Top module: `lpi_pend_tracker`

## Requirements
- R1: After reset: busy, lpi_en, best_valid, mem_re and mem_we are 0, and best_prio is 0xFF.
- R2: A request has no effect (no memory access, best unchanged) in any of these cases: LPIs are disabled; either base is zero; the ID is below 8192; or the ID is at least 2^(n+1), where n = min(id_bits, IDB_MAX).
- R3: An accepted request reads the byte at pend_base + ID/8 and flips bit ID mod 8 toward the requested level. The byte is written back only when the bit differs from the level.
- R4: The configuration byte of an ID is at prop_base + (ID − 8192). Bit 0 is the enable bit and bits [7:2] are the priority field. An entry with bit 0 clear never becomes the best.
- R5: With sec_dis=1 the priority is {cfg[7:2],2'b00}. With sec_dis=0 it is ({cfg[7:2],2'b00} >> 1) | 0x80.
- R6: A candidate becomes the best when its priority is numerically lower, or when the priority is equal and its ID is less than or equal to the best ID.
- R7: Setting a bit compares only that ID against the best. Clearing an ID that is not the best leaves the best unchanged. Clearing the best ID starts a full rescan.
- R8: A rescan first sets best_valid to 0 and best_prio to 0xFF. It then reads pending bytes upward from byte 1024 to byte 2^(n+1)/8 − 1, and tests the set bits of each byte from bit 0 up. If no enabled pending LPI is found, best_valid stays 0.
- R9: A control write acts only when cap_lpi=1. Enabling sets lpi_en and rescans, provided both bases are nonzero. Disabling clears lpi_en and leaves the best outputs unchanged.
- R10: busy is high for the whole of a read-modify-write or rescan. Requests and control writes made while busy are dropped. A control write made in the same cycle as a request wins, and the request is dropped.
- R11: mem_re and mem_we are never high together, and both are low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Set/clear request strobe |
| req_id | input | ID_W | Interrupt ID of the request |
| req_level | input | 1 | 1 sets the pending bit, 0 clears it |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value carried by the control write |
| cap_lpi | input | 1 | LPI support capability |
| sec_dis | input | 1 | Security disabled: selects the priority transform |
| prop_base | input | AW | Configuration table base address |
| pend_base | input | AW | Pending table base address |
| id_bits | input | 5 | Programmed ID width field |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_re |
| busy | output | 1 | Operation in progress |
| lpi_en | output | 1 | LPI enable state |
| best_valid | output | 1 | A best pending LPI exists |
| best_id | output | ID_W | ID of the best pending LPI |
| best_prio | output | 8 | Priority of the best pending LPI (0xFF when none) |

## Verification
Some rules are checked on every cycle by assertions. These cover the exclusive and quiet memory strobes, and a write always going to the address read two cycles earlier. They also cover the tie between best_valid and the 0xFF priority, that requests made while disabled are dropped, and that a control write without the capability bit is ignored. The bench scenarios are needed for the rest. Only they can show which ID wins after an incremental set, an equal-priority tie or a rescan, and that the two priority transforms are right. They also show whether the pending byte in memory really changed and whether a redundant write was skipped. All of these depend on table contents and on the history of earlier requests.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  localparam int LPI_FIRST = 8192;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWAIT, ST_PDATA, ST_PPOST,
    ST_CWAIT, ST_CDATA, ST_SWAIT, ST_SDATA, ST_SBIT
  } lpi_state_t;

  // priority derived from a configuration byte
  function automatic logic [7:0] cfg_prio(input logic [7:0] cfg, input logic sd);
    logic [7:0] fld;
    fld = {cfg[7:2], 2'b00};
    return sd ? fld : {1'b1, fld[7:1]};
  endfunction
endpackage

// File: rtl/lpi_req_gate.sv
module lpi_req_gate import lpi_pkg::*; #(
  parameter int AW      = 32,
  parameter int ID_W    = 16,
  parameter int IDB_MAX = 13,
  parameter int SB_W    = IDB_MAX - 1
) (
  input  logic [AW-1:0]   prop_base,
  input  logic [AW-1:0]   pend_base,
  input  logic [4:0]      id_bits,
  input  logic [ID_W-1:0] req_id,
  output logic            bases_ok,
  output logic            id_ok,
  output logic [SB_W-1:0] scan_end
);
  localparam int TW = ID_W + 1;
  logic [4:0]    idb;
  logic [TW-1:0] tbl_ids;
  logic [TW-1:0] id_ext;

  always_comb begin
    idb      = (id_bits > 5'(IDB_MAX)) ? 5'(IDB_MAX) : id_bits;
    tbl_ids  = TW'(1) << (idb + 5'd1);
    id_ext   = {1'b0, req_id};
    bases_ok = (prop_base != '0) && (pend_base != '0);
    id_ok    = (id_ext >= TW'(LPI_FIRST)) && (id_ext < tbl_ids);
    scan_end = SB_W'(tbl_ids >> 3);
  end
endmodule

// File: rtl/lpi_prio_cmp.sv
module lpi_prio_cmp import lpi_pkg::*; #(
  parameter int ID_W = 16
) (
  input  logic [7:0]      cfg,
  input  logic            sec_dis,
  input  logic [ID_W-1:0] cand_id,
  input  logic            best_valid,
  input  logic [7:0]      best_prio,
  input  logic [ID_W-1:0] best_id,
  output logic [7:0]      cand_prio,
  output logic            take
);
  always_comb begin
    cand_prio = cfg_prio(cfg, sec_dis);
    take = cfg[0] && (!best_valid || (cand_prio < best_prio) ||
                      ((cand_prio == best_prio) && (cand_id <= best_id)));
  end
endmodule

// File: rtl/lpi_bit_pick.sv
module lpi_bit_pick #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lpi_pend_tracker.sv
module lpi_pend_tracker import lpi_pkg::*; #(
  parameter int AW      = 32,
  parameter int ID_W    = 16,
  parameter int IDB_MAX = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic            req_level,
  input  logic            ctl_wr,
  input  logic            ctl_enable,
  input  logic            cap_lpi,
  input  logic            sec_dis,
  input  logic [AW-1:0]   prop_base,
  input  logic [AW-1:0]   pend_base,
  input  logic [4:0]      id_bits,
  output logic            mem_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            lpi_en,
  output logic            best_valid,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio
);
  localparam int SB_W = IDB_MAX - 1;
  localparam logic [ID_W-1:0] FIRST_ID   = ID_W'(LPI_FIRST);
  localparam logic [SB_W-1:0] FIRST_BYTE = SB_W'(LPI_FIRST / 8);

  lpi_state_t      st;
  logic [ID_W-1:0] cur_id;
  logic            cur_lvl;
  logic            from_scan;
  logic [7:0]      pbyte;
  logic [SB_W-1:0] byte_idx;
  logic [SB_W-1:0] scan_end_q;

  logic            bases_ok, id_ok;
  logic [SB_W-1:0] scan_end_w;
  logic [7:0]      cand_prio;
  logic            take;
  logic            bit_any;
  logic [2:0]      bit_idx;
  logic [SB_W-1:0] next_byte;
  logic [7:0]      bit_mask;

  lpi_req_gate #(.AW(AW), .ID_W(ID_W), .IDB_MAX(IDB_MAX), .SB_W(SB_W)) u_gate (
    .prop_base(prop_base), .pend_base(pend_base), .id_bits(id_bits),
    .req_id(req_id), .bases_ok(bases_ok), .id_ok(id_ok), .scan_end(scan_end_w)
  );

  lpi_prio_cmp #(.ID_W(ID_W)) u_cmp (
    .cfg(mem_rdata), .sec_dis(sec_dis), .cand_id(cur_id),
    .best_valid(best_valid), .best_prio(best_prio), .best_id(best_id),
    .cand_prio(cand_prio), .take(take)
  );

  lpi_bit_pick #(.W(8), .IW(3)) u_pick (
    .vec(pbyte), .any(bit_any), .idx(bit_idx)
  );

  assign next_byte = byte_idx + SB_W'(1);
  assign bit_mask  = 8'b1 << cur_id[2:0];
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_id     <= '0;
      cur_lvl    <= 1'b0;
      from_scan  <= 1'b0;
      pbyte      <= '0;
      byte_idx   <= '0;
      scan_end_q <= '0;
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      lpi_en     <= 1'b0;
      best_valid <= 1'b0;
      best_id    <= '0;
      best_prio  <= 8'hFF;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ctl_wr) begin
            if (cap_lpi) begin
              if (ctl_enable) begin
                lpi_en <= 1'b1;
                if (bases_ok) begin
                  best_valid <= 1'b0;
                  best_prio  <= 8'hFF;
                  byte_idx   <= FIRST_BYTE;
                  scan_end_q <= scan_end_w;
                  if (scan_end_w > FIRST_BYTE) begin
                    mem_re   <= 1'b1;
                    mem_addr <= pend_base + AW'(FIRST_BYTE);
                    st       <= ST_SWAIT;
                  end
                end
              end else begin
                lpi_en <= 1'b0;
              end
            end
          end else if (req_valid && lpi_en && bases_ok && id_ok) begin
            cur_id   <= req_id;
            cur_lvl  <= req_level;
            mem_re   <= 1'b1;
            mem_addr <= pend_base + AW'(req_id >> 3);
            st       <= ST_PWAIT;
          end
        end
        ST_PWAIT: st <= ST_PDATA;
        ST_PDATA: begin
          if (mem_rdata[cur_id[2:0]] == cur_lvl) begin
            st <= ST_IDLE;
          end else begin
            mem_we    <= 1'b1;
            mem_wdata <= cur_lvl ? (mem_rdata | bit_mask) : (mem_rdata & ~bit_mask);
            st        <= ST_PPOST;
          end
        end
        ST_PPOST: begin
          if (cur_lvl) begin
            from_scan <= 1'b0;
            mem_re    <= 1'b1;
            mem_addr  <= prop_base + AW'(cur_id - FIRST_ID);
            st        <= ST_CWAIT;
          end else if (best_valid && (best_id == cur_id)) begin
            best_valid <= 1'b0;
            best_prio  <= 8'hFF;
            byte_idx   <= FIRST_BYTE;
            scan_end_q <= scan_end_w;
            if (scan_end_w > FIRST_BYTE) begin
              mem_re   <= 1'b1;
              mem_addr <= pend_base + AW'(FIRST_BYTE);
              st       <= ST_SWAIT;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_CWAIT: st <= ST_CDATA;
        ST_CDATA: begin
          if (take) begin
            best_valid <= 1'b1;
            best_id    <= cur_id;
            best_prio  <= cand_prio;
          end
          st <= from_scan ? ST_SBIT : ST_IDLE;
        end
        ST_SWAIT: st <= ST_SDATA;
        ST_SDATA: begin
          pbyte <= mem_rdata;
          st    <= ST_SBIT;
        end
        ST_SBIT: begin
          if (bit_any) begin
            pbyte     <= pbyte & ~(8'b1 << bit_idx);
            cur_id    <= ID_W'({byte_idx, bit_idx});
            from_scan <= 1'b1;
            mem_re    <= 1'b1;
            mem_addr  <= prop_base + AW'(ID_W'({byte_idx, bit_idx}) - FIRST_ID);
            st        <= ST_CWAIT;
          end else if (next_byte >= scan_end_q) begin
            st <= ST_IDLE;
          end else begin
            byte_idx <= next_byte;
            mem_re   <= 1'b1;
            mem_addr <= pend_base + AW'(next_byte);
            st       <= ST_SWAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_re && !mem_we));
  // R3
  rmw_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(mem_re, 2) && ($past(mem_addr, 2) == mem_addr)));
  // R8
  none_prio_chk: assert property (@(posedge clk) disable iff (rst) !best_valid |-> (best_prio == 8'hFF));
  // R5
  valid_prio_chk: assert property (@(posedge clk) disable iff (rst) best_valid |-> (best_prio != 8'hFF));
  // R2
  drop_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctl_wr && req_valid && !lpi_en) |=> !busy);
  // R9
  no_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctl_wr && !cap_lpi) |=> ($stable(lpi_en) && !busy));
  // R9
  disable_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctl_wr && cap_lpi && !ctl_enable) |=> (!lpi_en && $stable(best_valid) && $stable(best_id)));
endmodule

// File: tb/sim_lpi_pend_tracker.sv
`timescale 1ns/1ps
module sim_lpi_pend_tracker;
  localparam int AW = 32, ID_W = 16, IDB_MAX = 13;
  localparam int PB = 32'h1000, CB = 32'h2000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_level = 0, ctl_wr = 0, ctl_enable = 0, cap_lpi = 0, sec_dis = 0;
  logic [ID_W-1:0] req_id = '0;
  logic [AW-1:0] prop_base = '0, pend_base = '0;
  logic [4:0] id_bits = 5'd13;
  logic mem_re, mem_we, busy, lpi_en, best_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, best_prio;
  logic [ID_W-1:0] best_id;

  always #4 clk = ~clk;

  lpi_pend_tracker #(.AW(AW), .ID_W(ID_W), .IDB_MAX(IDB_MAX)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_level(req_level),
    .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .cap_lpi(cap_lpi), .sec_dis(sec_dis),
    .prop_base(prop_base), .pend_base(pend_base), .id_bits(id_bits),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .lpi_en(lpi_en), .best_valid(best_valid),
    .best_id(best_id), .best_prio(best_prio));

  logic [7:0] mem [0:16383];
  int wr_cnt = 0, clash_cnt = 0;
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[13:0]];
    if (mem_we) begin mem[mem_addr[13:0]] <= mem_wdata; wr_cnt++; end
    if (mem_re && mem_we) clash_cnt++;
  end

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // reference model
  bit pend_m [0:16383];
  bit en_m = 0, mb_v = 0;
  int mb_id = 0, mb_p = 8'hFF;

  function automatic int prio_of(input logic [7:0] c, input bit sd);
    int f = c & 8'hFC;
    return sd ? f : ((f >> 1) | 8'h80);
  endfunction
  task automatic cand(input int id);
    logic [7:0] c = mem[CB + id - 8192];
    int p = prio_of(c, sec_dis);
    if (c[0] && (!mb_v || p < mb_p || (p == mb_p && id <= mb_id))) begin
      mb_v = 1; mb_id = id; mb_p = p;
    end
  endtask
  task automatic rescan();
    int n = (id_bits > IDB_MAX) ? IDB_MAX : int'(id_bits);
    mb_v = 0; mb_p = 8'hFF;
    for (int id = 8192; id < (1 << (n + 1)); id++) if (pend_m[id]) cand(id);
  endtask
  function automatic bit accept(input int id);
    int n = (id_bits > IDB_MAX) ? IDB_MAX : int'(id_bits);
    return en_m && prop_base != 0 && pend_base != 0 && id >= 8192 && id < (1 << (n + 1));
  endfunction

  typedef struct { bit v; int id; int prio; bit en; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic push(input string tag);
    exp_t e;
    e.v = mb_v; e.id = mb_id; e.prio = mb_p; e.en = en_m; e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  // monitor
  initial forever begin
    exp_t e;
    wait (sb_q.size() != 0);
    @(negedge clk);
    while (busy) @(negedge clk);
    e = sb_q[0];
    check(best_valid == e.v, {e.tag, " valid"}, best_valid, e.v);
    if (e.v) begin
      check(best_id == e.id, {e.tag, " id"}, best_id, e.id);
      check(best_prio == e.prio, {e.tag, " prio"}, best_prio, e.prio);
    end else check(best_prio == 8'hFF, {e.tag, " prio none"}, best_prio, 8'hFF);
    check(lpi_en == e.en, {e.tag, " lpi_en"}, lpi_en, e.en);
    void'(sb_q.pop_front());
  end

  task automatic do_req(input int id, input bit lvl, input string tag);
    @(negedge clk);
    req_valid = 1; req_id = ID_W'(id); req_level = lvl;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    if (accept(id) && pend_m[id] != lvl) begin
      pend_m[id] = lvl;
      if (lvl) cand(id);
      else if (mb_v && mb_id == id) rescan();
    end
    push(tag);
  endtask

  task automatic do_ctl(input bit en, input string tag);
    @(negedge clk);
    ctl_wr = 1; ctl_enable = en;
    @(negedge clk);
    ctl_wr = 0;
    while (busy) @(negedge clk);
    if (cap_lpi) begin
      if (en) begin en_m = 1; if (prop_base != 0 && pend_base != 0) rescan(); end
      else en_m = 0;
    end
    push(tag);
  endtask

  function automatic bit pbit(input int id);
    return mem[PB + id / 8][id % 8];
  endfunction
  task automatic preload(input int id);
    mem[PB + id / 8][id % 8] = 1'b1; pend_m[id] = 1;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    for (int i = 0; i < 16384; i++) mem[i] = 8'h00;
    mem[CB + 8200 - 8192]  = 8'h41;
    mem[CB + 9000 - 8192]  = 8'h21;
    mem[CB + 9500 - 8192]  = 8'h10;
    mem[CB + 10000 - 8192] = 8'h0B;
    mem[CB + 12000 - 8192] = 8'h81;
    mem[CB + 9600 - 8192]  = 8'h09;
    mem[CB + 11000 - 8192] = 8'h09;
    preload(8200); preload(9000); preload(9500);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !lpi_en && !best_valid && !mem_re && !mem_we, "R1 reset flags",
          {busy, lpi_en, best_valid, mem_re, mem_we}, 0);
    check(best_prio == 8'hFF, "R1 reset prio", best_prio, 8'hFF);

    prop_base = CB; pend_base = PB;
    // R2 disabled: clear dropped
    do_req(8200, 0, "R2 disabled");
    check(pbit(8200) == 1, "R2 disabled bit kept", pbit(8200), 1);
    // R9 no capability
    do_ctl(1, "R9 no cap");
    cap_lpi = 1;
    // R8 R4 enable rescan, disabled entry 9500 skipped
    do_ctl(1, "R8 enable rescan");
    check(best_id == 9000, "R4 disabled entry skipped", best_id, 9000);
    // R3 set new bit, better prio
    w0 = wr_cnt;
    do_req(10000, 1, "R7 set better");
    check(pbit(10000) == 1, "R3 bit set", pbit(10000), 1);
    check(wr_cnt == w0 + 1, "R3 one write", wr_cnt - w0, 1);
    w0 = wr_cnt;
    do_req(10000, 1, "R3 redundant set");
    check(wr_cnt == w0, "R3 write skipped", wr_cnt - w0, 0);
    do_req(12000, 1, "R7 set worse");
    check(pbit(12000) == 1, "R3 worse bit set", pbit(12000), 1);
    // R6 ties
    do_req(9600, 1, "R6 tie lower id");
    do_req(11000, 1, "R6 tie higher id");
    // R7 clears
    do_req(12000, 0, "R7 clear other");
    check(pbit(12000) == 0, "R3 bit cleared", pbit(12000), 0);
    do_req(9600, 0, "R7 clear best rescan");
    check(best_id == 10000, "R8 rescan tie lowest id", best_id, 10000);
    // R2 range
    do_req(100, 1, "R2 below range");
    check(mem[PB + 12] == 0, "R2 low id no write", mem[PB + 12], 0);
    do_req(16384, 1, "R2 above range");
    check(mem[PB + 2048] == 0, "R2 high id no write", mem[PB + 2048], 0);
    id_bits = 5'd12;
    do_req(8300, 1, "R2 small table");
    check(pbit(8300) == 0, "R2 small table no write", pbit(8300), 0);
    id_bits = 5'd20;
    do_req(16384, 1, "R2 clamp");
    check(mem[PB + 2048] == 0, "R2 clamp no write", mem[PB + 2048], 0);
    id_bits = 5'd13;
    // R5 secure-disabled transform
    sec_dis = 1;
    do_ctl(1, "R5 sec_dis rescan");
    check(best_prio == 8'h08, "R5 raw field", best_prio, 8'h08);
    // R2 zero base
    pend_base = '0;
    w0 = wr_cnt;
    do_req(8400, 1, "R2 zero base");
    check(wr_cnt == w0, "R2 zero base no write", wr_cnt - w0, 0);
    pend_base = PB;
    // R10 collision and requests while busy
    @(negedge clk);
    ctl_wr = 1; ctl_enable = 1; req_valid = 1; req_id = ID_W'(8500); req_level = 1;
    @(negedge clk);
    ctl_wr = 0;
    check(busy == 1, "R10 busy during rescan", busy, 1);
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    rescan();
    push("R10 ctl wins");
    check(pbit(8500) == 0, "R10 request dropped", pbit(8500), 0);
    // R9 disable keeps best
    do_ctl(0, "R9 disable");
    do_req(8201, 1, "R9 disabled req");
    check(pbit(8201) == 0, "R9 disabled no write", pbit(8201), 0);
    do_ctl(1, "R9 reenable");
    // R8 drain to empty
    do_req(8200, 0, "R7 drain a");
    do_req(9000, 0, "R7 drain b");
    do_req(9500, 0, "R7 drain c");
    do_req(11000, 0, "R7 drain d");
    do_req(10000, 0, "R8 drain empty");
    check(best_valid == 0, "R8 none found", best_valid, 0);
    // R11
    check(clash_cnt == 0, "R11 strobes exclusive", clash_cnt, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule